// File: doc/BRIEF.md
# Vectored Interrupt Controller with Bit-Atomic Enables

This block collects up to 32 interrupt lines into one request for a processor. A build-time map gives each line a fixed sensitivity: rising edge, falling edge, level high or level low. A detected event sets that line's bit in a capture register. The bit stays set until software clears it by writing a one to it. A mask register selects which captured lines count. Software changes the mask in one of two ways. It can overwrite the whole mask, or it can touch single bits through write-only set and clear ports, so no read-modify-write is needed.

The processor request is the OR of all unmasked captured lines. Two control bits gate it, and it is asserted only when both are on. A read-only vector register returns the number of the lowest active line, so the handler can branch on it directly. Register access is a simple single-cycle write strobe plus a word index. Read data follows the index combinationally.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The word index selects the register: 0 capture, 1 active (masked), 2 mask, 3 clear-capture, 4 mask-set, 5 mask-clear, 6 vector, 7 control. Line n maps to bit n of every per-line register.
- R2: Reset empties the capture, mask and control registers. After reset, `irq_req` is low and the vector reads 0xFFFFFFFF.
- R3: Line n takes its sensitivity from bits [2n+1:2n] of `SENSE_MAP`. The codes are 0 rising edge, 1 falling edge, 2 level high and 3 level low. The default map gives line n the code n mod 4. An event sets the capture bit at the next clock edge, whatever the mask holds.
- R4: A level line whose input is still active sets its capture bit again one clock after that bit is cleared. An edge line sets its bit again only on a new edge.
- R5: A write to word 2 replaces the whole mask.
- R6: A write to word 4 sets the mask bits where the data has ones. All other mask bits are left unchanged.
- R7: A write to word 5 clears the mask bits where the data has ones. All other mask bits are left unchanged.
- R8: A write to word 3 clears each capture bit where the data has a one. In that cycle the clear wins over a new event on the same line. Writing all ones clears every bit.
- R9: Word 1 reads the capture register ANDed with the mask.
- R10: Word 6 reads the number of the lowest-numbered active line. It reads 0xFFFFFFFF when no line is active.
- R11: Word 7 holds two bits: bit 0 is the global on, and bit 1 is the output permit. `irq_req` is high exactly when some line is active and both bits are set.
- R12: Words 3, 4 and 5 read as zero. Writes to words 0, 1 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt lines |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_word | input | 3 | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the indexed word |
| irq_req | output | 1 | Request to the processor |

## Verification
A wrong capture bit appears at word 0 one clock after the event that set it. It also reaches words 1 and 6 and `irq_req` in that same cycle, once the line is unmasked. A corrupted mask or control bit shows in the next read of word 2 or word 7. It also shows at once on `irq_req` whenever a captured line depends on that bit. The bench therefore compares a randomly chosen register and the request line against a reference model on every cycle. A fault shows up within a cycle or two of the clock edge that caused it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_HIGH = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  localparam logic [2:0] W_CAPTURE = 3'd0;
  localparam logic [2:0] W_ACTIVE  = 3'd1;
  localparam logic [2:0] W_MASK    = 3'd2;
  localparam logic [2:0] W_CLRCAP  = 3'd3;
  localparam logic [2:0] W_MSET    = 3'd4;
  localparam logic [2:0] W_MCLR    = 3'd5;
  localparam logic [2:0] W_VECTOR  = 3'd6;
  localparam logic [2:0] W_CTRL    = 3'd7;

  // Event detection for one line, from its current and previous samples.
  function automatic logic line_event(sense_e s, logic now, logic prev);
    case (s)
      SENSE_RISE: line_event = now & ~prev;
      SENSE_FALL: line_event = ~now & prev;
      SENSE_HIGH: line_event = now;
      default:    line_event = ~now;
    endcase
  endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter logic [2*NUM_LINES-1:0] SENSE_MAP = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] capture,
  output logic [NUM_LINES-1:0] evt
);

  logic [NUM_LINES-1:0] prev_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam sense_e LINE_SENSE = sense_e'(SENSE_MAP[2*g+1:2*g]);
    assign evt[g] = line_event(LINE_SENSE, irq_in[g], prev_q[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      capture <= '0;
    end else begin
      prev_q  <= irq_in;
      capture <= (capture | evt) & ~clr_mask;
    end
  end

  // R8: a clear leaves the named bits empty on the following cycle
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((capture & $past(clr_mask)) == '0));

  // R3: a bit is never dropped without a clear
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((capture & $past(capture)) == $past(capture)));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [2:0]           bus_word,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [NUM_LINES-1:0] mask,
  output logic [1:0]           ctrl,
  output logic [NUM_LINES-1:0] clr_mask
);

  logic [NUM_LINES-1:0] wbits;
  logic wr_mask, wr_set, wr_clr, wr_ctrl, wr_clrcap;

  assign wbits     = bus_wdata[NUM_LINES-1:0];
  assign wr_mask   = bus_wr && (bus_word == W_MASK);
  assign wr_set    = bus_wr && (bus_word == W_MSET);
  assign wr_clr    = bus_wr && (bus_word == W_MCLR);
  assign wr_ctrl   = bus_wr && (bus_word == W_CTRL);
  assign wr_clrcap = bus_wr && (bus_word == W_CLRCAP);
  assign clr_mask  = wr_clrcap ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      ctrl <= 2'b00;
    end else begin
      if (wr_mask)      mask <= wbits;
      else if (wr_set)  mask <= mask | wbits;
      else if (wr_clr)  mask <= mask & ~wbits;
      if (wr_ctrl)      ctrl <= bus_wdata[1:0];
    end
  end

  // R6: set port turns on named bits and leaves the others alone
  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (((mask & $past(wbits)) == $past(wbits)) &&
                (((mask ^ $past(mask)) & ~$past(wbits)) == '0)));

  // R7: clear port turns off named bits and leaves the others alone
  a_r7_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (((mask & $past(wbits)) == '0) &&
                (((mask ^ $past(mask)) & ~$past(wbits)) == '0)));

  // R12: the mask moves only through its three write words
  a_r12_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mask || wr_set || wr_clr) |=> $stable(mask));

  // R11: control changes only on its own write
  a_r11_ctrl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NUM_LINES = 32,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] active,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);

  // Scan from the top so the lowest-numbered line is written last and wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (active[i]) begin
        found = 1'b1;
        idx   = i[IDX_W-1:0];
      end
    end
  end

  // R10: the reported line is active whenever one is found
  always_comb begin
    if (found) a_r10_idx_active: assert (active[idx]);
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter logic [2*NUM_LINES-1:0] SENSE_MAP = 64'hE4E4_E4E4_E4E4_E4E4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic [2:0]           bus_word,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_req
);

  logic [NUM_LINES-1:0] capture, evt, mask, clr_mask, active;
  logic [1:0]           ctrl;
  logic                 found;
  logic [IDX_W-1:0]     idx;

  irqc_capture #(.NUM_LINES(NUM_LINES), .SENSE_MAP(SENSE_MAP)) u_capture (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_mask(clr_mask),
    .capture(capture), .evt(evt)
  );

  irqc_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .mask(mask), .ctrl(ctrl), .clr_mask(clr_mask)
  );

  assign active = capture & mask;

  irqc_prio #(.NUM_LINES(NUM_LINES)) u_prio (
    .active(active), .found(found), .idx(idx)
  );

  assign irq_req = found && (ctrl == 2'b11);

  always_comb begin
    bus_rdata = '0;
    case (bus_word)
      W_CAPTURE: bus_rdata[NUM_LINES-1:0] = capture;
      W_ACTIVE:  bus_rdata[NUM_LINES-1:0] = active;
      W_MASK:    bus_rdata[NUM_LINES-1:0] = mask;
      W_VECTOR:  if (found) bus_rdata[IDX_W-1:0] = idx;
                 else       bus_rdata = '1;
      W_CTRL:    bus_rdata[1:0] = ctrl;
      default:   bus_rdata = '0;
    endcase
  end

  // R11: request needs both control bits and an active line
  a_r11_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((ctrl == 2'b11) && (active != '0)));

  // R10: no line found means nothing is active
  a_r10_none_found: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (active == '0));

  // R9: a masked line never reaches the request
  a_r9_masked_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_req);

  // R4: clear of an event-free line keeps it empty next cycle
  a_r4_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~evt) != '0) |=> ((capture & $past(clr_mask & ~evt)) == '0));

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_wr;
  logic [2:0]  bus_word;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  localparam logic [31:0] IDLE = 32'hAAAA_AAAA;

  always #5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req)
  );

  logic [31:0] m_cap, m_mask, m_prev;
  logic [1:0]  m_ctrl;

  // Line n has sensitivity code n mod 4 (R3).
  function automatic logic [31:0] f_evt(input logic [31:0] now, input logic [31:0] prev);
    for (int n = 0; n < 32; n++) begin
      case (n % 4)
        0: f_evt[n] = now[n] && !prev[n];
        1: f_evt[n] = !now[n] && prev[n];
        2: f_evt[n] = now[n];
        default: f_evt[n] = !now[n];
      endcase
    end
  endfunction

  function automatic logic [31:0] f_vec(input logic [31:0] act);
    f_vec = 32'hFFFF_FFFF;
    for (int n = 0; n < 32; n++) begin
      if (act[n] && f_vec == 32'hFFFF_FFFF) f_vec = n;
    end
  endfunction

  function automatic logic [31:0] f_read(input logic [2:0] w);
    case (w)
      3'd0: f_read = m_cap;
      3'd1: f_read = m_cap & m_mask;
      3'd2: f_read = m_mask;
      3'd6: f_read = f_vec(m_cap & m_mask);
      3'd7: f_read = {30'b0, m_ctrl};
      default: f_read = 32'h0;
    endcase
  endfunction

  function automatic string f_tag(input logic [2:0] w);
    case (w)
      3'd0: f_tag = "R3";
      3'd1: f_tag = "R9";
      3'd2: f_tag = "R5";
      3'd6: f_tag = "R10";
      3'd7: f_tag = "R11";
      default: f_tag = "R12";
    endcase
  endfunction

  task automatic step(input logic w, input logic [2:0] i, input logic [31:0] d,
                      input logic [31:0] inp);
    logic [31:0] clr;
    irq_in = inp; bus_wr = w; bus_word = i; bus_wdata = d;
    @(posedge clk);
    clr = (w && i == 3'd3) ? d : 32'h0;
    m_cap = (m_cap | f_evt(inp, m_prev)) & ~clr;
    if (w) begin
      case (i)
        3'd2: m_mask = d;
        3'd4: m_mask = m_mask | d;
        3'd5: m_mask = m_mask & ~d;
        3'd7: m_ctrl = d[1:0];
        default: ;
      endcase
    end
    m_prev = inp;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input logic [2:0] w, input string tag);
    logic [31:0] exp;
    logic        exp_req;
    bus_word = w;
    #1;
    exp = f_read(w);
    n_checks++;
    if (bus_rdata !== exp) begin
      n_fails++;
      $display("FAIL %s R1 word %0d got %h exp %h", tag, w, bus_rdata, exp);
    end
    exp_req = ((m_cap & m_mask) != 0) && (m_ctrl == 2'b11);
    n_checks++;
    if (irq_req !== exp_req) begin
      n_fails++;
      $display("FAIL R11 irq_req got %0b exp %0b", irq_req, exp_req);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int w = 0; w < 8; w++) chk(3'(w), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cur;
    void'($urandom(32'd1234));
    rst_n = 1'b0; irq_in = IDLE; bus_wr = 1'b0; bus_word = 3'd0; bus_wdata = 32'h0;
    m_cap = 0; m_mask = 0; m_prev = 0; m_ctrl = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk_all("R2");
    step(1'b0, 3'd0, 32'h0, IDLE);
    chk_all("R2");

    // R11 and R5: turn on, full mask
    step(1'b1, 3'd7, 32'h3, IDLE);
    step(1'b1, 3'd2, 32'hFFFF_FFFF, IDLE);
    chk(3'd7, "R11"); chk(3'd2, "R5");

    // R3, R10: level-high line 2, then rising line 0 becomes lowest
    cur = IDLE | 32'h4;
    step(1'b0, 3'd0, 32'h0, cur);
    chk(3'd0, "R3"); chk(3'd6, "R10");
    cur = cur | 32'h1;
    step(1'b0, 3'd0, 32'h0, cur);
    chk(3'd6, "R10"); chk(3'd1, "R9");

    // R8 then R4: clear all, level line returns, edge line does not
    step(1'b1, 3'd3, 32'hFFFF_FFFF, cur);
    chk(3'd0, "R8");
    step(1'b0, 3'd0, 32'h0, cur);
    chk(3'd0, "R4"); chk(3'd6, "R4");

    // R12: writes to read-only words change nothing
    step(1'b1, 3'd0, 32'h0, cur);
    chk(3'd0, "R12");
    step(1'b1, 3'd6, 32'h0, cur);
    chk(3'd6, "R12"); chk(3'd3, "R12"); chk(3'd4, "R12"); chk(3'd5, "R12");

    // R7, R6: bit-atomic mask updates
    step(1'b1, 3'd5, 32'h0000_0004, cur);
    chk(3'd2, "R7"); chk(3'd6, "R7");
    step(1'b1, 3'd4, 32'h0000_0004, cur);
    chk(3'd2, "R6"); chk(3'd6, "R6");

    // R11: only one control bit set
    step(1'b1, 3'd7, 32'h1, cur);
    chk(3'd7, "R11");
    step(1'b1, 3'd7, 32'h2, cur);
    chk(3'd7, "R11");
    step(1'b1, 3'd7, 32'h3, cur);
    chk(3'd7, "R11");

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [2:0]  wi;
      logic [31:0] wd;
      logic        ww;
      cur = cur ^ ($urandom & $urandom & $urandom);
      ww  = $urandom_range(0, 1) == 1;
      wi  = 3'($urandom_range(0, 7));
      wd  = (wi == 3'd3) ? ($urandom & $urandom) : $urandom;
      step(ww, wi, wd, cur);
      begin
        logic [2:0] rw;
        rw = 3'($urandom_range(0, 7));
        chk(rw, f_tag(rw));
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule